// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD clock/calendar and raises an alarm when the time reaches a programmed value. Six alarm fields (seconds, minutes, hours, date, month, day of week) are supplied to it; the top bit of each field selects whether that field takes part in the comparison, the lower bits hold the BCD value. The comparison is evaluated only on the cycle that carries the one-second update strobe, so an alarm fires once, on entry into the matching second.

The result is kept in a status flag and signalled on an active-low interrupt pin. In latched mode the pin stays low as long as the flag is set. In repeating mode every match sets the flag and drives a fixed-length low pulse, timed in cycles of the 32.768 kHz clock (8192 cycles, 250 ms). Software clears the flag by writing 0, or, with auto-clear on, by a status read closed by a STOP; a match that fires inside that read window survives the STOP. The same pin carries a frequency waveform when a non-zero frequency select is programmed, which also disables the alarm, and it can be forced inactive while the system runs from backup supply.

Top module: `cal_alarm_top`

## Requirements
- R1: On a cycle with tick_i high, if every field whose enable bit (bit 7) is 1 has bits 6:0 equal to the matching time input (time bit 7 is 0), alm_o is 1 from the next cycle on.
- R2: A field whose bit 7 is 0 is ignored by the comparison; if no field has bit 7 set, no alarm ever fires.
- R3: Without tick_i the alarm never fires, whatever the time and alarm inputs are.
- R4: When alm_en_i is 0 or fsel_i is non-zero, a matching tick leaves alm_o at 0.
- R5: With irq_mode_i 0 (latched), irq_pin_no is 0 exactly while alm_o is 1 (frequency select 0, pin not disabled).
- R6: With irq_mode_i 1 (repeating), each match sets alm_o and drives irq_pin_no low for PULSE_CYC cycles starting the cycle after the tick; afterwards the pin is high even if alm_o stays 1.
- R7: A status write with stat_wr_alm_i 0 clears alm_o; with stat_wr_alm_i 1 it has no effect; a match in the same cycle as a clearing write leaves alm_o at 1.
- R8: With auto_clr_i 1, a stat_rd_i pulse that sees alm_o at 1 followed by rd_stop_i clears alm_o; with auto_clr_i 0 the same sequence leaves it set.
- R9: If a match fires after the stat_rd_i pulse and before or on the rd_stop_i pulse, alm_o stays 1 after the STOP.
- R10: When fsel_i is non-zero, irq_pin_no equals fout_i.
- R11: When on_batt_i and bat_irq_dis_i are both 1, irq_pin_no is 1.
- R12: After reset alm_o is 0 and irq_pin_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe when the time inputs enter a new second |
| sec_i | input | FIELD_W | Current seconds, BCD |
| min_i | input | FIELD_W | Current minutes, BCD |
| hour_i | input | FIELD_W | Current hours, BCD |
| date_i | input | FIELD_W | Current day of month, BCD |
| month_i | input | FIELD_W | Current month, BCD |
| wday_i | input | FIELD_W | Current day of week |
| al_sec_i | input | FIELD_W | Alarm seconds, bit 7 enable |
| al_min_i | input | FIELD_W | Alarm minutes, bit 7 enable |
| al_hour_i | input | FIELD_W | Alarm hours, bit 7 enable |
| al_date_i | input | FIELD_W | Alarm date, bit 7 enable |
| al_month_i | input | FIELD_W | Alarm month, bit 7 enable |
| al_wday_i | input | FIELD_W | Alarm day of week, bit 7 enable |
| alm_en_i | input | 1 | Global alarm enable |
| irq_mode_i | input | 1 | 0 latched, 1 repeating pulse |
| auto_clr_i | input | 1 | Clear flag on completed status read |
| fsel_i | input | FSEL_W | Frequency select; non-zero hands the pin to fout_i |
| bat_irq_dis_i | input | 1 | Disable pin while on backup supply |
| on_batt_i | input | 1 | System running from backup supply |
| fout_i | input | 1 | Frequency waveform for the shared pin |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wr_alm_i | input | 1 | Alarm flag bit value of that write |
| stat_rd_i | input | 1 | Status byte captured by a read |
| rd_stop_i | input | 1 | STOP ending that read |
| alm_o | output | 1 | Alarm status flag |
| irq_pin_no | output | 1 | Shared active-low interrupt / frequency pin |

## Verification
The assertions take the update strobe and the status strobes to be single-cycle pulses, a STOP to follow its status capture, and the time inputs to carry bit 7 at zero and stay stable around a tick. The bench drives every strobe for exactly one cycle from the falling edge, changes time and alarm values only between strobes, and keeps ticks far apart relative to the pulse length except where a match is deliberately placed inside a read window.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned DEF_FIELD_W = 8;
  localparam int unsigned DEF_FSEL_W = 4;
  localparam int unsigned DEF_PULSE_CYC = 8192;
endpackage

// File: rtl/cal_field_match.sv
module cal_field_match #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic [FIELD_W-1:0] alarm_i,
  input  logic [FIELD_W-1:0] time_i,
  output logic               en_o,
  output logic               hit_o
);
  localparam int unsigned VAL_W = FIELD_W - 1;

  logic [FIELD_W-1:0] ref_val;

  assign en_o    = alarm_i[FIELD_W-1];
  assign ref_val = {1'b0, alarm_i[VAL_W-1:0]};
  // disabled field always passes
  assign hit_o   = !en_o || (ref_val == time_i);
endmodule

// File: rtl/cal_alarm_status.sv
module cal_alarm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic stat_wr_i,
  input  logic wr_bit_i,
  input  logic stat_rd_i,
  input  logic rd_stop_i,
  input  logic auto_clr_i,
  output logic alm_o
);
  logic alm_q, alm_d;
  logic seen_q, seen_d;

  always_comb begin
    alm_d  = alm_q;
    seen_d = seen_q;
    if (fire_i) begin
      alm_d  = 1'b1;
      seen_d = 1'b0;   // new alarm must survive the pending STOP
    end else begin
      if (stat_wr_i && !wr_bit_i) alm_d = 1'b0;
      else if (rd_stop_i && auto_clr_i && seen_q) alm_d = 1'b0;
      if (stat_rd_i) seen_d = alm_q;
      else if (rd_stop_i) seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      alm_q  <= alm_d;
      seen_q <= seen_d;
    end
  end

  assign alm_o = alm_q;
endmodule

// File: rtl/cal_alarm_pulse.sv
module cal_alarm_pulse #(
  parameter int unsigned PULSE_CYC = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W   = DEF_FIELD_W,
  parameter int unsigned FSEL_W    = DEF_FSEL_W,
  parameter int unsigned PULSE_CYC = DEF_PULSE_CYC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] date_i,
  input  logic [FIELD_W-1:0] month_i,
  input  logic [FIELD_W-1:0] wday_i,
  input  logic [FIELD_W-1:0] al_sec_i,
  input  logic [FIELD_W-1:0] al_min_i,
  input  logic [FIELD_W-1:0] al_hour_i,
  input  logic [FIELD_W-1:0] al_date_i,
  input  logic [FIELD_W-1:0] al_month_i,
  input  logic [FIELD_W-1:0] al_wday_i,
  input  logic               alm_en_i,
  input  logic               irq_mode_i,
  input  logic               auto_clr_i,
  input  logic [FSEL_W-1:0]  fsel_i,
  input  logic               bat_irq_dis_i,
  input  logic               on_batt_i,
  input  logic               fout_i,
  input  logic               stat_wr_i,
  input  logic               stat_wr_alm_i,
  input  logic               stat_rd_i,
  input  logic               rd_stop_i,
  output logic               alm_o,
  output logic               irq_pin_no
);
  logic [FIELD_W-1:0] al_arr [NUM_FIELDS];
  logic [FIELD_W-1:0] tm_arr [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_vec, hit_vec;

  assign al_arr[0] = al_sec_i;   assign tm_arr[0] = sec_i;
  assign al_arr[1] = al_min_i;   assign tm_arr[1] = min_i;
  assign al_arr[2] = al_hour_i;  assign tm_arr[2] = hour_i;
  assign al_arr[3] = al_date_i;  assign tm_arr[3] = date_i;
  assign al_arr[4] = al_month_i; assign tm_arr[4] = month_i;
  assign al_arr[5] = al_wday_i;  assign tm_arr[5] = wday_i;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    cal_field_match #(.FIELD_W(FIELD_W)) u_match (
      .alarm_i (al_arr[g]),
      .time_i  (tm_arr[g]),
      .en_o    (en_vec[g]),
      .hit_o   (hit_vec[g])
    );
  end

  logic fout_mode, match, fire, pulse_act, low_req, pin_off;

  assign fout_mode = (fsel_i != '0);
  assign match     = (&hit_vec) && (|en_vec);
  assign fire      = tick_i && alm_en_i && !fout_mode && match;

  cal_alarm_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .stat_wr_i  (stat_wr_i),
    .wr_bit_i   (stat_wr_alm_i),
    .stat_rd_i  (stat_rd_i),
    .rd_stop_i  (rd_stop_i),
    .auto_clr_i (auto_clr_i),
    .alm_o      (alm_o)
  );

  cal_alarm_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fire && irq_mode_i),
    .active_o (pulse_act)
  );

  assign pin_off = on_batt_i && bat_irq_dis_i;

  always_comb begin
    if (fout_mode)       low_req = !fout_i;
    else if (irq_mode_i) low_req = pulse_act;
    else                 low_req = alm_o;
  end

  assign irq_pin_no = pin_off ? 1'b1 : !low_req;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned FSEL_W    = 4,
  parameter int unsigned PULSE_CYC = 8192
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [FIELD_W-1:0] sec_i,
  input logic [FIELD_W-1:0] min_i,
  input logic [FIELD_W-1:0] hour_i,
  input logic [FIELD_W-1:0] date_i,
  input logic [FIELD_W-1:0] month_i,
  input logic [FIELD_W-1:0] wday_i,
  input logic [FIELD_W-1:0] al_sec_i,
  input logic [FIELD_W-1:0] al_min_i,
  input logic [FIELD_W-1:0] al_hour_i,
  input logic [FIELD_W-1:0] al_date_i,
  input logic [FIELD_W-1:0] al_month_i,
  input logic [FIELD_W-1:0] al_wday_i,
  input logic               alm_en_i,
  input logic               irq_mode_i,
  input logic               auto_clr_i,
  input logic [FSEL_W-1:0]  fsel_i,
  input logic               bat_irq_dis_i,
  input logic               on_batt_i,
  input logic               fout_i,
  input logic               stat_wr_i,
  input logic               stat_wr_alm_i,
  input logic               stat_rd_i,
  input logic               rd_stop_i,
  input logic               alm_o,
  input logic               irq_pin_no
);
  localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2) + 1;
  logic [RUN_W-1:0] low_run;

  // length of the current low stretch in repeating mode, restarted by each tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run <= '0;
    else if (tick_i || !irq_mode_i || fsel_i != '0 || irq_pin_no) low_run <= '0;
    else low_run <= low_run + 1'b1;
  end

  assert_rise_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_o) |-> $past(tick_i));

  assert_rise_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_o) |-> ($past(alm_en_i) && $past(fsel_i) == '0));

  assert_wr_one_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && stat_wr_alm_i && alm_o && !rd_stop_i) |=> alm_o);

  assert_fall_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alm_o) |-> ($past(stat_wr_i && !stat_wr_alm_i) || $past(rd_stop_i && auto_clr_i)));

  assert_latched_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_mode_i && alm_o && fsel_i == '0 && !(on_batt_i && bat_irq_dis_i)) |-> !irq_pin_no);

  assert_batt_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_batt_i && bat_irq_dis_i) |-> irq_pin_no);

  assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= RUN_W'(PULSE_CYC));
endmodule

bind cal_alarm_top cal_alarm_chk #(
  .FIELD_W(FIELD_W), .FSEL_W(FSEL_W), .PULSE_CYC(PULSE_CYC)
) u_chk (.*);

// File: tb/tb_cal_alarm_top.sv
module tb_cal_alarm_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 8192;
  localparam int NVEC = 8;

  // {alarm sec,min,hour,date,month,wday, time sec,min,hour,date,month,wday, expected}
  localparam logic [96:0] VEC [NVEC] = '{
    {48'hB0_00_00_00_00_00, 48'h30_12_09_15_06_03, 1'b1},
    {48'hB0_00_00_00_00_00, 48'h31_12_09_15_06_03, 1'b0},
    {48'hA3_C5_97_A1_83_82, 48'h23_45_17_21_03_02, 1'b1},
    {48'hA3_C5_97_A1_83_82, 48'h23_45_17_21_03_03, 1'b0},
    {48'h00_00_88_00_00_00, 48'h42_07_08_30_11_05, 1'b1},
    {48'h23_45_17_21_03_02, 48'h23_45_17_21_03_02, 1'b0},
    {48'h59_80_00_00_00_00, 48'h10_00_22_01_01_01, 1'b1},
    {48'h00_00_00_00_92_00, 48'h00_00_00_01_11_01, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0;
  logic [7:0] tsec = 0, tmin = 0, thour = 0, tdate = 0, tmonth = 0, twday = 0;
  logic [7:0] asec = 0, amin = 0, ahour = 0, adate = 0, amonth = 0, awday = 0;
  logic alm_en = 1, irq_mode = 0, auto_clr = 0, bat_dis = 0, on_batt = 0, fout = 1;
  logic [3:0] fsel = 0;
  logic stat_wr = 0, stat_wr_alm = 0, stat_rd = 0, rd_stop = 0;
  logic alm, pin;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .sec_i(tsec), .min_i(tmin), .hour_i(thour), .date_i(tdate), .month_i(tmonth), .wday_i(twday),
    .al_sec_i(asec), .al_min_i(amin), .al_hour_i(ahour), .al_date_i(adate),
    .al_month_i(amonth), .al_wday_i(awday),
    .alm_en_i(alm_en), .irq_mode_i(irq_mode), .auto_clr_i(auto_clr), .fsel_i(fsel),
    .bat_irq_dis_i(bat_dis), .on_batt_i(on_batt), .fout_i(fout),
    .stat_wr_i(stat_wr), .stat_wr_alm_i(stat_wr_alm), .stat_rd_i(stat_rd), .rd_stop_i(rd_stop),
    .alm_o(alm), .irq_pin_no(pin)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic do_wr(input logic b);
    @(negedge clk) begin stat_wr = 1; stat_wr_alm = b; end
    @(negedge clk) stat_wr = 0;
  endtask

  task automatic do_rd();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) rd_stop = 1;
    @(negedge clk) rd_stop = 0;
  endtask

  // alarm 23:45:17 on the 21st of March, weekday 2, all fields enabled
  task automatic load_full_match();
    {asec, amin, ahour, adate, amonth, awday} = 48'hA3_C5_97_A1_83_82;
    {tsec, tmin, thour, tdate, tmonth, twday} = 48'h23_45_17_21_03_02;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 alm after reset", alm, 0);
    check("R12 pin after reset", pin, 1);
    rst_ni = 1;
    @(negedge clk);

    // table walk, latched mode: R1 R2 R5
    for (int i = 0; i < NVEC; i++) begin
      {asec, amin, ahour, adate, amonth, awday} = VEC[i][96:49];
      {tsec, tmin, thour, tdate, tmonth, twday} = VEC[i][48:1];
      do_wr(0);
      do_tick();
      check($sformatf("R1 R2 vector %0d alm", i), alm, VEC[i][0]);
      check($sformatf("R5 vector %0d pin", i), pin, !VEC[i][0]);
    end

    // R3: matching time, no tick
    do_wr(0);
    load_full_match();
    repeat (5) @(negedge clk);
    check("R3 no tick", alm, 0);

    // R4: global enable off, then frequency select on
    alm_en = 0; do_tick();
    check("R4 alm_en=0", alm, 0);
    alm_en = 1; fsel = 4'h4; do_tick();
    check("R4 fsel!=0", alm, 0);
    // R10: pin follows waveform
    fout = 0; @(negedge clk);
    check("R10 fout low", pin, 0);
    fout = 1; @(negedge clk);
    check("R10 fout high", pin, 1);
    fsel = 0;

    // R7: write semantics
    do_tick();
    check("R7 set", alm, 1);
    do_wr(1);
    check("R7 write 1 no effect", alm, 1);
    do_wr(0);
    check("R7 write 0 clears", alm, 0);
    @(negedge clk) begin tick = 1; stat_wr = 1; stat_wr_alm = 0; end
    @(negedge clk) begin tick = 0; stat_wr = 0; end
    check("R7 fire beats clear", alm, 1);

    // R8: read plus STOP
    auto_clr = 0; do_rd(); do_stop();
    check("R8 no auto clear", alm, 1);
    auto_clr = 1; do_rd(); do_stop();
    check("R8 auto clear", alm, 0);

    // R9: fire inside read window, both with flag already set and clear
    do_tick(); do_rd(); do_tick(); do_stop();
    check("R9 fire during read, was set", alm, 1);
    do_wr(0); do_rd(); do_tick(); do_stop();
    check("R9 fire during read, was clear", alm, 1);
    auto_clr = 0;

    // R11: battery disable
    on_batt = 1; bat_dis = 1; @(negedge clk);
    check("R11 pin released", pin, 1);
    bat_dis = 0; @(negedge clk);
    check("R11 pin active without disable", pin, 0);
    on_batt = 0;

    // R6: repeating pulse
    do_wr(0);
    irq_mode = 1;
    check("R6 idle pin", pin, 1);
    do_tick();
    check("R6 flag set", alm, 1);
    begin
      int n = 0;
      while (!pin && n < PULSE + 100) begin n++; @(negedge clk); end
      check("R6 pulse length", n, PULSE);
    end
    check("R6 pin high with flag set", pin, 1);
    check("R6 flag kept", alm, 1);
    do_tick();
    check("R6 second pulse starts", pin, 0);

    finish_run();
  end
endmodule